// File: doc/BRIEF.md
# USB IN Endpoint Transmit Controller

This block is the transmit half of a single USB device IN endpoint whose largest packet is eight bytes. Software loads payload bytes one at a time into a small transmit buffer through a narrow register bus. It then either fills the buffer completely or commits a shorter packet, including a zero-length one. A control/status register reports whether the buffer is free. It also reports packet completion, underrun and sent-stall events, and it holds a forced-stall control and a buffer-flush command.

On the host side, an abstract token interface signals each IN token. The block answers each token with DATA, NAK or STALL and streams the packet bytes under a ready handshake. A host ACK pulse retires the packet. A packet that is not acknowledged stays in the buffer and goes out again on the next IN token. An interrupt request combines the completion and stall flags and is gated by an enable register that comes out of reset in the disabled state.

Top module: `usb_in_ep_tx`

## Requirements
- R1: After reset the status register (address 1) reads 0x01: only the buffer-free bit, bit 0, is set. The interrupt control register (address 2) reads 0x01. The irq output is low. Bits 31:8 and bit 6 of the status register always read 0.
- R2: A write to address 0 appends bus_wdata to the buffer. The write is ignored while the buffer already holds 8 bytes or while a short packet is committed. Bit 0 reads 1 only when the buffer is empty and no packet is committed.
- R3: While the force-stall bit (bit 5, read/write) is 1, every IN token is answered with STALL (resp_kind 2'b11), whatever the buffer holds, and the sent-stall flag (bit 4) is set.
- R4: An IN token that finds neither 8 buffered bytes nor a committed short packet is answered with NAK (resp_kind 2'b10), and the buffer and status are left as they were.
- R5: With 8 bytes buffered, an IN token is answered with DATA (resp_kind 2'b01) one cycle later. The 8 bytes then stream out in load order on tx_data, one per cycle in which tx_valid and tx_ready are both high. tx_done marks the end of the packet.
- R6: Writing 1 to bit 7 commits the buffered bytes as a short packet, and bit 7 reads back as 1. The next IN token sends exactly those bytes. With an empty buffer it sends a zero-length packet, where tx_done rises with no byte transferred.
- R7: A packet that receives no host_ack is sent again, byte for byte, on the next IN token.
- R8: host_ack after a complete packet empties the buffer, sets the completion bit (bit 1) and clears bit 7.
- R9: Bits 1, 3 and 4 are cleared by writing 1 to them. Writing 0 to them has no effect. The flush bit (bit 2) always reads 0.
- R10: Writing 1 to bit 2 empties the buffer and cancels a committed short packet.
- R11: If the buffer runs empty while a packet is streaming (a flush during transfer), the packet ends at once with tx_done. The underrun bit (bit 3) and bit 1 are set, and no further byte is sent.
- R12: irq is high exactly when the completion or sent-stall flag is set and bit 0 of the interrupt control register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 buffer data, 1 status/control, 2 interrupt control |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| tok_in | input | 1 | One-cycle pulse: IN token received |
| host_ack | input | 1 | One-cycle pulse: host acknowledged the data packet |
| resp_valid | output | 1 | One-cycle pulse: handshake answer available |
| resp_kind | output | 2 | Answer: 01 DATA, 10 NAK, 11 STALL |
| tx_valid | output | 1 | Packet byte available on tx_data |
| tx_data | output | 8 | Packet byte |
| tx_ready | input | 1 | Downstream accepts the byte this cycle |
| tx_done | output | 1 | End of the packet being streamed |
| irq | output | 1 | Endpoint interrupt request |

## Verification
Several properties are checked on every cycle. Every token outside a transfer is answered in the following cycle, and a STALL answer always comes with the sent-stall flag. An acknowledged packet leaves the buffer empty with completion flagged. The buffer never exceeds its capacity, the masked interrupt stays low, and the flush and reserved bits read zero. Byte order, retransmission of an unacknowledged packet, ignored writes, the zero-length case and the flush-induced underrun depend on multi-step histories, so only the directed scenarios of the bench show them.

// File: rtl/usbin_pkg.sv
package usbin_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CSR  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd2;

    // status/control bit positions
    localparam int B_FREE   = 0;
    localparam int B_DONE   = 1;
    localparam int B_FLUSH  = 2;
    localparam int B_UNDER  = 3;
    localparam int B_STSENT = 4;
    localparam int B_FORCE  = 5;
    localparam int B_SHORT  = 7;

    typedef enum logic [1:0] {
        RESP_NONE  = 2'b00,
        RESP_DATA  = 2'b01,
        RESP_NAK   = 2'b10,
        RESP_STALL = 2'b11
    } resp_e;

    typedef enum logic [1:0] {
        ENG_IDLE    = 2'd0,
        ENG_STREAM  = 2'd1,
        ENG_WAITACK = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic short_rdy;
        logic force_stall;
        logic stall_sent;
        logic underrun;
        logic pkt_done;
    } ep_flags_t;

    typedef struct packed {
        logic sent;
        logic underrun;
        logic stall;
    } eng_evt_t;

    function automatic logic [BUS_W-1:0] pack_status(ep_flags_t f, logic free);
        logic [BUS_W-1:0] v;
        v           = '0;
        v[B_FREE]   = free;
        v[B_DONE]   = f.pkt_done;
        v[B_UNDER]  = f.underrun;
        v[B_STSENT] = f.stall_sent;
        v[B_FORCE]  = f.force_stall;
        v[B_SHORT]  = f.short_rdy;
        return v;
    endfunction

endpackage

// File: rtl/usbin_txbuf.sv
module usbin_txbuf #(
    parameter int MAX_PKT = 8,
    parameter int BYTE_W  = 8,
    localparam int IW = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
    localparam int CW = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              lock,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              clear,
    input  logic [IW-1:0]     rd_idx,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [CW-1:0]     fill,
    output logic              full
);
    logic [BYTE_W-1:0] mem [MAX_PKT];
    logic              accept;

    assign full   = (fill == CW'(MAX_PKT));
    assign accept = wr_en && !full && !lock;

    genvar g;
    generate
        for (g = 0; g < MAX_PKT; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (accept && !clear && fill == CW'(g))
                    mem[g] <= wr_byte;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear)
            fill <= '0;
        else if (accept)
            fill <= fill + 1'b1;
    end

    assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/usbin_csr.sv
module usbin_csr
    import usbin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_csr,
    input  logic      wr_ien,
    input  logic [7:0] wdata,
    input  eng_evt_t  evt,
    output logic      flush,
    output ep_flags_t flags,
    output logic      ien_mask,
    output logic      irq
);
    logic finish;

    assign flush  = wr_csr && wdata[B_FLUSH];
    assign finish = evt.sent || evt.underrun;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            ien_mask <= 1'b1;
        end else begin
            // completion: hardware set wins over software clear
            if (finish)
                flags.pkt_done <= 1'b1;
            else if (wr_csr && wdata[B_DONE])
                flags.pkt_done <= 1'b0;

            if (evt.underrun)
                flags.underrun <= 1'b1;
            else if (wr_csr && wdata[B_UNDER])
                flags.underrun <= 1'b0;

            if (evt.stall)
                flags.stall_sent <= 1'b1;
            else if (wr_csr && wdata[B_STSENT])
                flags.stall_sent <= 1'b0;

            if (wr_csr)
                flags.force_stall <= wdata[B_FORCE];

            if (finish || flush)
                flags.short_rdy <= 1'b0;
            else if (wr_csr && wdata[B_SHORT])
                flags.short_rdy <= 1'b1;

            if (wr_ien)
                ien_mask <= wdata[0];
        end
    end

    assign irq = (flags.pkt_done || flags.stall_sent) && !ien_mask;
endmodule

// File: rtl/usbin_engine.sv
module usbin_engine
    import usbin_pkg::*;
#(
    parameter int MAX_PKT = 8,
    localparam int IW = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
    localparam int CW = $clog2(MAX_PKT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_in,
    input  logic          host_ack,
    input  logic          tx_ready,
    input  logic          flush,
    input  logic [CW-1:0] fill,
    input  logic          full,
    input  logic          short_rdy,
    input  logic          force_stall,
    output logic [IW-1:0] rd_idx,
    output logic          resp_valid,
    output resp_e         resp_kind,
    output logic          tx_valid,
    output logic          tx_done,
    output logic          streaming,
    output logic          waiting,
    output eng_evt_t      evt
);
    eng_state_e    state;
    logic [CW-1:0] len;
    logic [CW-1:0] idx;
    logic          more, have, ready_pkt;

    assign streaming = (state == ENG_STREAM);
    assign waiting   = (state == ENG_WAITACK);
    assign more      = idx < len;
    assign have      = idx < fill;
    assign ready_pkt = full || short_rdy;

    assign tx_valid = streaming && more && have;
    assign tx_done  = streaming && !(more && have);
    assign rd_idx   = idx[IW-1:0];

    always_comb begin
        evt          = '0;
        evt.underrun = streaming && more && !have;
        evt.stall    = tok_in && !streaming && force_stall;
        evt.sent     = waiting && host_ack && !tok_in && !flush;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ENG_IDLE;
            len        <= '0;
            idx        <= '0;
            resp_valid <= 1'b0;
            resp_kind  <= RESP_NONE;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (tok_in) begin
                        resp_valid <= 1'b1;
                        if (force_stall) begin
                            resp_kind <= RESP_STALL;
                        end else if (ready_pkt) begin
                            resp_kind <= RESP_DATA;
                            len       <= fill;
                            idx       <= '0;
                            state     <= ENG_STREAM;
                        end else begin
                            resp_kind <= RESP_NAK;
                        end
                    end
                end
                ENG_STREAM: begin
                    if (tx_done)
                        state <= evt.underrun ? ENG_IDLE : ENG_WAITACK;
                    else if (tx_valid && tx_ready)
                        idx <= idx + 1'b1;
                end
                ENG_WAITACK: begin
                    if (flush) begin
                        state <= ENG_IDLE;
                    end else if (tok_in) begin
                        resp_valid <= 1'b1;
                        if (force_stall) begin
                            resp_kind <= RESP_STALL;
                        end else begin
                            resp_kind <= RESP_DATA;
                            idx       <= '0;
                            state     <= ENG_STREAM;
                        end
                    end else if (host_ack) begin
                        state <= ENG_IDLE;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usb_in_ep_tx.sv
module usb_in_ep_tx
    import usbin_pkg::*;
#(
    parameter int MAX_PKT = 8,
    localparam int IW = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
    localparam int CW = $clog2(MAX_PKT + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tok_in,
    input  logic        host_ack,
    output logic        resp_valid,
    output logic [1:0]  resp_kind,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        tx_done,
    output logic        irq
);
    ep_flags_t     flags;
    eng_evt_t      evt;
    resp_e         resp_e_w;
    logic          flush, ien_mask, full, streaming, waiting, buf_clear;
    logic [CW-1:0] fill;
    logic [IW-1:0] rd_idx;

    assign buf_clear = flush || evt.sent || evt.underrun;

    usbin_txbuf #(.MAX_PKT(MAX_PKT), .BYTE_W(8)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr && bus_addr == ADDR_DATA),
        .lock    (flags.short_rdy),
        .wr_byte (bus_wdata),
        .clear   (buf_clear),
        .rd_idx  (rd_idx),
        .rd_byte (tx_data),
        .fill    (fill),
        .full    (full)
    );

    usbin_csr u_csr (
        .clk      (clk),
        .rst      (rst),
        .wr_csr   (bus_wr && bus_addr == ADDR_CSR),
        .wr_ien   (bus_wr && bus_addr == ADDR_IEN),
        .wdata    (bus_wdata),
        .evt      (evt),
        .flush    (flush),
        .flags    (flags),
        .ien_mask (ien_mask),
        .irq      (irq)
    );

    usbin_engine #(.MAX_PKT(MAX_PKT)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .tok_in      (tok_in),
        .host_ack    (host_ack),
        .tx_ready    (tx_ready),
        .flush       (flush),
        .fill        (fill),
        .full        (full),
        .short_rdy   (flags.short_rdy),
        .force_stall (flags.force_stall),
        .rd_idx      (rd_idx),
        .resp_valid  (resp_valid),
        .resp_kind   (resp_e_w),
        .tx_valid    (tx_valid),
        .tx_done     (tx_done),
        .streaming   (streaming),
        .waiting     (waiting),
        .evt         (evt)
    );

    assign resp_kind = resp_e_w;

    always_comb begin
        case (bus_addr)
            ADDR_CSR: bus_rdata = pack_status(flags, fill == '0 && !flags.short_rdy);
            ADDR_IEN: bus_rdata = {{(BUS_W-1){1'b0}}, ien_mask};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/usb_in_ep_tx_chk.sv
module usb_in_ep_tx_chk #(
    parameter int MAX_PKT = 8,
    localparam int CW = $clog2(MAX_PKT + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          tok_in,
    input logic          host_ack,
    input logic          resp_valid,
    input logic [1:0]    resp_kind,
    input logic          streaming,
    input logic          waiting,
    input logic          flush,
    input logic          stall_sent,
    input logic          pkt_done,
    input logic          ien_mask,
    input logic          irq,
    input logic [CW-1:0] fill,
    input logic [1:0]    bus_addr,
    input logic [31:0]   bus_rdata
);
    AST_TOKEN_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        tok_in && !streaming |=> resp_valid);                          // R4

    AST_STALL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_kind == 2'b11 |-> stall_sent);              // R3

    AST_ACK_FREES: assert property (@(posedge clk) disable iff (rst)
        host_ack && waiting && !tok_in && !flush |=> fill == '0 && pkt_done); // R8

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(MAX_PKT));                                          // R2

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        ien_mask |-> !irq);                                             // R12

    AST_FLUSH_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_addr == 2'd1 |-> !bus_rdata[2]);                            // R9

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_addr == 2'd1 |-> bus_rdata[31:8] == '0 && !bus_rdata[6]);   // R1
endmodule

bind usb_in_ep_tx usb_in_ep_tx_chk #(.MAX_PKT(MAX_PKT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tok_in     (tok_in),
    .host_ack   (host_ack),
    .resp_valid (resp_valid),
    .resp_kind  (resp_kind),
    .streaming  (streaming),
    .waiting    (waiting),
    .flush      (flush),
    .stall_sent (flags.stall_sent),
    .pkt_done   (flags.pkt_done),
    .ien_mask   (ien_mask),
    .irq        (irq),
    .fill       (fill),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata)
);

// File: tb/usb_in_ep_tx_test.sv
module usb_in_ep_tx_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        bus_wr = 0;
    logic [1:0]  bus_addr = 0;
    logic [7:0]  bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        tok_in = 0, host_ack = 0, tx_ready = 1;
    logic        resp_valid, tx_valid, tx_done, irq;
    logic [1:0]  resp_kind;
    logic [7:0]  tx_data;

    int n_chk = 0, n_fail = 0;
    logic [7:0] got [16];
    int         n_got;
    logic       got_done;

    usb_in_ep_tx uut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic token(output logic v, output logic [1:0] k);
        @(negedge clk); tok_in = 1;
        @(negedge clk); tok_in = 0;
        v = resp_valid; k = resp_kind;
    endtask

    task automatic collect();
        n_got = 0; got_done = 0;
        for (int k = 0; k < 20; k++) begin
            if (tx_valid) begin got[n_got] = tx_data; n_got++; end
            if (tx_done) begin got_done = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic ack();
        @(negedge clk); host_ack = 1;
        @(negedge clk); host_ack = 0;
    endtask

    task automatic load(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) wr(2'd0, base + 8'(i));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd1, d); chk("R1 status after reset", d, 32'h01);
        rd(2'd2, d); chk("R1 intctl after reset", d, 32'h01);
        chk("R1 irq after reset", irq, 0);
    endtask

    task automatic t_nak();
        logic v; logic [1:0] k; logic [31:0] d;
        token(v, k);
        chk("R4 nak on empty", {v, k}, 3'b110);
        load(3, 8'h30);
        token(v, k);
        chk("R4 nak partial", {v, k}, 3'b110);
        rd(2'd1, d); chk("R4 state unchanged / R2 not free", d, 32'h00);
    endtask

    task automatic t_short();
        logic v; logic [1:0] k; logic [31:0] d;
        wr(2'd1, 8'h80);
        rd(2'd1, d); chk("R6 short bit reads back", d, 32'h80);
        wr(2'd0, 8'hEE);  // ignored: packet committed
        token(v, k);
        chk("R6 short data resp", {v, k}, 3'b101);
        collect();
        chk("R6 short length", n_got, 3);
        chk("R2 write after commit ignored", got[2], 8'h32);
        chk("R6 short bytes", {got[0], got[1]}, 16'h3031);
        ack();
        rd(2'd1, d); chk("R8 after ack", d, 32'h03);
        wr(2'd1, 8'h02);
        rd(2'd1, d); chk("R9 completion cleared", d, 32'h01);
    endtask

    task automatic t_zlp();
        logic v; logic [1:0] k; logic [31:0] d;
        wr(2'd1, 8'h80);
        rd(2'd1, d); chk("R6 zlp committed", d, 32'h80);
        token(v, k);
        chk("R6 zlp resp", {v, k}, 3'b101);
        collect();
        chk("R6 zlp no bytes", {got_done, 8'(n_got)}, {1'b1, 8'd0});
        ack();
        rd(2'd1, d); chk("R8 zlp ack", d, 32'h03);
        wr(2'd1, 8'h02);
    endtask

    task automatic t_full_resend();
        logic v; logic [1:0] k; logic [31:0] d; logic ok;
        load(9, 8'hA0);  // ninth ignored
        token(v, k);
        chk("R5 full data resp", {v, k}, 3'b101);
        collect();
        chk("R5 full length", n_got, 8);
        ok = 1;
        for (int i = 0; i < 8; i++) if (got[i] !== 8'hA0 + 8'(i)) ok = 0;
        chk("R5 byte order", ok, 1);
        token(v, k);
        chk("R7 resend resp", {v, k}, 3'b101);
        collect();
        ok = (n_got == 8);
        for (int i = 0; i < 8; i++) if (got[i] !== 8'hA0 + 8'(i)) ok = 0;
        chk("R7 resend same bytes", ok, 1);
        ack();
        rd(2'd1, d); chk("R8 full ack / R2 ninth dropped", d, 32'h03);
        // R12 interrupt gating
        chk("R12 masked irq", irq, 0);
        wr(2'd2, 8'h00);
        @(negedge clk); chk("R12 irq enabled", irq, 1);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R9 write 0 no effect", d, 32'h03);
        wr(2'd1, 8'h02);
        @(negedge clk); chk("R12 irq drops", irq, 0);
    endtask

    task automatic t_stall();
        logic v; logic [1:0] k; logic [31:0] d;
        load(8, 8'h10);
        wr(2'd1, 8'h20);
        token(v, k);
        chk("R3 stall over full", {v, k}, 3'b111);
        rd(2'd1, d); chk("R3 stall flags", d, 32'h30);
        chk("R12 irq on stall", irq, 1);
        wr(2'd1, 8'h30);
        rd(2'd1, d); chk("R9 stall-sent cleared", d, 32'h20);
        wr(2'd1, 8'h04);  // clear force, flush
        rd(2'd1, d); chk("R10 flush empties / R9 flush reads 0", d, 32'h01);
        load(2, 8'h50);
        wr(2'd1, 8'h80);
        wr(2'd1, 8'h04);
        rd(2'd1, d); chk("R10 flush cancels short", d, 32'h01);
        token(v, k);
        chk("R10 nak after flush", {v, k}, 3'b110);
    endtask

    task automatic t_underrun();
        logic v; logic [1:0] k; logic [31:0] d;
        load(8, 8'hC0);
        token(v, k);
        chk("R5 data resp", {v, k}, 3'b101);
        chk("R11 first byte", {tx_valid, tx_data}, {1'b1, 8'hC0});
        bus_addr = 2'd1; bus_wdata = 8'h04; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
        chk("R11 early end", {tx_valid, tx_done}, 2'b01);
        @(negedge clk);
        chk("R11 no more bytes", tx_valid, 0);
        rd(2'd1, d); chk("R11 underrun flags", d, 32'h0B);
        wr(2'd1, 8'h0A);
        rd(2'd1, d); chk("R9 underrun cleared", d, 32'h01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_nak();
        t_short();
        t_zlp();
        t_full_resend();
        t_stall();
        t_underrun();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule